// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits between four peripheral DMA request lines and the host processor's bus-hold handshake. It registers the request inputs on every clock edge and, while no channel owns the bus, decides whether any unmasked request is pending. If one is pending, it raises a bus-request output to the processor. Once the processor returns hold-acknowledge, the block picks the winning channel and drives that channel's active-low acknowledge.

The grant stays fixed until the owning channel finishes. A channel finishes when its registered request falls or when the terminal-count input is high. At that point the bus request is released and a one-cycle completion pulse is produced. The block then waits for hold-acknowledge to fall before it starts a new arbitration round.

Two priority schemes are available. In the fixed scheme, the lowest channel index always wins. In the rotating scheme, the channel just serviced moves to the bottom of the order. A single command write loads the per-channel mask, the priority mode and a global disable together. Address generation, byte counting and data movement belong to other blocks.

Top module: `dmaArbiter`

## Requirements
- R1: A synchronous reset drives `busReq` low, all `chAckN` bits high, `ownerDone` low, sets every mask bit, selects fixed priority and clears the global disable.
- R2: With the block idle and enabled, an unmasked request applied before clock edge k drives `busReq` high after edge k+1 (edge k registers the request, edge k+1 enters the asking state).
- R3: No acknowledge is driven before hold-acknowledge. A grant appears after the first edge at which `holdAck` is high while the block is asking. If every unmasked request is withdrawn before then, `busReq` falls without any grant.
- R4: `chAckN[i]` low means channel i owns the bus. At most one bit of `chAckN` is low at a time.
- R5: In fixed mode (rotate bit 0), the pending unmasked channel with the lowest index wins.
- R6: In rotating mode (rotate bit 1), after channel k is serviced the order becomes k+1, k+2, … with k last, wrapping modulo four.
- R7: A grant is held until an edge at which either the owner's registered request is low or `tcIn` is high. At that edge the acknowledge clears, `busReq` falls and `ownerDone` is high for exactly one cycle.
- R8: After a release, `busReq` stays low, even with requests pending, until `holdAck` has been sampled low.
- R9: A masked channel's request neither raises `busReq` nor wins a grant. A command write (`cmdWrEn` high at an edge) loads the mask (bit i masks channel i), the rotate bit and the disable bit together.
- R10: While the global disable is set, `busReq` is never raised, any current grant ends at the next edge as in R7, and pending requests are left waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chReq | input | NUM_CH | Per-channel service requests, active high |
| tcIn | input | 1 | Terminal count of the owning channel; ends its service |
| holdAck | input | 1 | Hold-acknowledge from the host processor |
| cmdWrEn | input | 1 | Loads the three command fields below |
| cmdMaskIn | input | NUM_CH | New mask, bit i set masks channel i |
| cmdRotateIn | input | 1 | New priority mode: 0 fixed, 1 rotating |
| cmdDisableIn | input | 1 | New global disable |
| busReq | output | 1 | Bus request to the host processor |
| chAckN | output | NUM_CH | Per-channel acknowledge, active low, at most one low |
| ownerDone | output | 1 | One-cycle pulse after an ownership ends |

## Verification
The bench builds the block with its default of four channels. This width is small enough that every rotation pointer value and every wrap from channel 3 back to channel 0 appears within a few service rounds. Holding all four requests high in rotating mode walks the grant through each pointer position. The same setup in fixed mode shows channel 0 starving the others. Driving hold-acknowledge by hand, instead of from the automatic host model, brings the delayed-grant case and the wait for hold-acknowledge to fall into reach.

// File: rtl/dmaArbPkg.sv
package dmaArbPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_OWN  = 2'd2,
    ST_FREE = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeGrant;  // latch the arbitration winner
    logic dropGrant;  // clear the grant, advance rotation, pulse done
  } arbStrobe_t;

endpackage

// File: rtl/dmaArbDatapath.sv
module dmaArbDatapath
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              tcIn,
  input  logic              cmdWrEn,
  input  logic [NUM_CH-1:0] cmdMaskIn,
  input  logic              cmdRotateIn,
  input  logic              cmdDisableIn,
  input  arbStrobe_t        strobe,
  output logic              anyReq,
  output logic              serviceEnd,
  output logic              disabled,
  output logic [NUM_CH-1:0] grantVec,
  output logic              ownerDone
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] reqSampled;
  logic [NUM_CH-1:0] maskReg;
  logic              rotateReg;
  logic              disableReg;
  logic [CH_W-1:0]   hiPtr;

  logic [NUM_CH-1:0] effReq;
  logic [NUM_CH-1:0] winVec;
  logic [CH_W-1:0]   grantIdx;
  logic [CH_W-1:0]   nextPtr;

  assign effReq   = reqSampled & ~maskReg;
  assign anyReq   = |effReq;
  assign disabled = disableReg;

  // priority search starting at the current top channel
  always_comb begin
    int  base;
    int  idx;
    logic found;
    winVec = '0;
    found  = 1'b0;
    base   = rotateReg ? int'(hiPtr) : 0;
    idx    = 0;
    for (int off = 0; off < NUM_CH; off++) begin
      idx = base + off;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!found && effReq[idx]) begin
        winVec[idx] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grantVec[i]) grantIdx = CH_W'(i);
    end
  end

  assign nextPtr = (grantIdx == LAST_IDX) ? '0 : grantIdx + CH_W'(1);

  assign serviceEnd = (|grantVec) &&
                      (tcIn || !(|(reqSampled & grantVec)) || disableReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      reqSampled <= '0;
      maskReg    <= '1;
      rotateReg  <= 1'b0;
      disableReg <= 1'b0;
      hiPtr      <= '0;
      grantVec   <= '0;
      ownerDone  <= 1'b0;
    end else begin
      reqSampled <= chReq;
      ownerDone  <= strobe.dropGrant;
      if (cmdWrEn) begin
        maskReg    <= cmdMaskIn;
        rotateReg  <= cmdRotateIn;
        disableReg <= cmdDisableIn;
      end
      if (strobe.takeGrant) begin
        grantVec <= winVec;
      end else if (strobe.dropGrant) begin
        grantVec <= '0;
        hiPtr    <= nextPtr;
      end
    end
  end

  // R4: at most one owner
  p_ack_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec));

  // R7: the owner never changes while the grant is held
  p_grant_held_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(|grantVec) && (|grantVec)) |-> (grantVec == $past(grantVec)));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ownerDone |=> !ownerDone);

  // R9: a freshly granted channel was not masked
  p_masked_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    ((|grantVec) && !$past(|grantVec)) |-> ((grantVec & $past(maskReg)) == '0));

  // R10: two cycles of disable leave no owner
  p_disable_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
    (disableReg && $past(disableReg)) |-> (grantVec == '0));

endmodule

// File: rtl/dmaArbControl.sv
module dmaArbControl
  import dmaArbPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       holdAck,
  input  logic       anyReq,
  input  logic       serviceEnd,
  input  logic       disabled,
  output logic       busReq,
  output arbStrobe_t strobe
);

  arbState_t state;
  arbState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!disabled && anyReq) nextState = ST_ASK;
      end
      ST_ASK: begin
        if (disabled || !anyReq) begin
          nextState = ST_IDLE;
        end else if (holdAck) begin
          nextState        = ST_OWN;
          strobe.takeGrant = 1'b1;
        end
      end
      ST_OWN: begin
        if (serviceEnd) begin
          nextState        = ST_FREE;
          strobe.dropGrant = 1'b1;
        end
      end
      ST_FREE: begin
        if (!holdAck) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  assign busReq = ((state == ST_ASK) && !disabled) || (state == ST_OWN);

  // R8: leaving the release state needs hold-acknowledge low
  p_free_until_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && ($past(state) == ST_FREE)) |-> !$past(holdAck));

endmodule

// File: rtl/dmaArbiter.sv
module dmaArbiter
  import dmaArbPkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chReq,
  input  logic              tcIn,
  input  logic              holdAck,
  input  logic              cmdWrEn,
  input  logic [NUM_CH-1:0] cmdMaskIn,
  input  logic              cmdRotateIn,
  input  logic              cmdDisableIn,
  output logic              busReq,
  output logic [NUM_CH-1:0] chAckN,
  output logic              ownerDone
);

  arbStrobe_t        strobe;
  logic              anyReq;
  logic              serviceEnd;
  logic              disabled;
  logic [NUM_CH-1:0] grantVec;

  dmaArbDatapath #(.NUM_CH(NUM_CH)) uData (
    .clk         (clk),
    .rst         (rst),
    .chReq       (chReq),
    .tcIn        (tcIn),
    .cmdWrEn     (cmdWrEn),
    .cmdMaskIn   (cmdMaskIn),
    .cmdRotateIn (cmdRotateIn),
    .cmdDisableIn(cmdDisableIn),
    .strobe      (strobe),
    .anyReq      (anyReq),
    .serviceEnd  (serviceEnd),
    .disabled    (disabled),
    .grantVec    (grantVec),
    .ownerDone   (ownerDone)
  );

  dmaArbControl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .holdAck   (holdAck),
    .anyReq    (anyReq),
    .serviceEnd(serviceEnd),
    .disabled  (disabled),
    .busReq    (busReq),
    .strobe    (strobe)
  );

  assign chAckN = ~grantVec;

  // R3: an owner only exists while the bus is requested
  p_ack_needs_bus_r3: assert property (@(posedge clk) disable iff (rst)
    (|grantVec) |-> busReq);

  // R3: a new grant follows a sampled hold-acknowledge
  p_grant_after_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((|grantVec) && !$past(|grantVec)) |-> $past(holdAck && busReq));

endmodule

// File: tb/tb_dmaArbiter.sv
module tb_dmaArbiter;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chReq = '0;
  logic           tcIn = 1'b0;
  logic           holdAck = 1'b0;
  logic           cmdWrEn = 1'b0;
  logic [NCH-1:0] cmdMaskIn = '0;
  logic           cmdRotateIn = 1'b0;
  logic           cmdDisableIn = 1'b0;
  logic           busReq;
  logic [NCH-1:0] chAckN;
  logic           ownerDone;

  dmaArbiter #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst(rst), .chReq(chReq), .tcIn(tcIn), .holdAck(holdAck),
    .cmdWrEn(cmdWrEn), .cmdMaskIn(cmdMaskIn), .cmdRotateIn(cmdRotateIn),
    .cmdDisableIn(cmdDisableIn), .busReq(busReq), .chAckN(chAckN),
    .ownerDone(ownerDone)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    nChecks = 0;
  int    nFail   = 0;
  string phaseTag = "R1";

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int             mSt = 0;     // 0 idle, 1 asking, 2 owned, 3 releasing
  int             mGrant = -1;
  int             mPtr = 0;
  bit             mDone = 0;
  logic [NCH-1:0] mReq = '0;
  logic [NCH-1:0] mMask = '1;
  bit             mRot = 0;
  bit             mDis = 0;

  always @(posedge clk) begin
    if (rst) begin
      mSt = 0; mGrant = -1; mPtr = 0; mDone = 0;
      mReq = '0; mMask = '1; mRot = 0; mDis = 0;
    end else begin
      logic [NCH-1:0] eff;
      int win;
      int nSt;
      eff = mReq & ~mMask;
      win = -1;
      for (int off = 0; off < NCH; off++) begin
        int c;
        c = ((mRot ? mPtr : 0) + off) % NCH;
        if (win < 0 && eff[c]) win = c;
      end
      nSt = mSt;
      mDone = 0;
      case (mSt)
        0: if (!mDis && eff != 0) nSt = 1;
        1: if (mDis || eff == 0) nSt = 0;
           else if (holdAck) begin nSt = 2; mGrant = win; end
        2: if (mDis || tcIn || !mReq[mGrant]) begin
             nSt = 3; mPtr = (mGrant + 1) % NCH; mGrant = -1; mDone = 1;
           end
        default: if (!holdAck) nSt = 0;
      endcase
      mSt = nSt;
      mReq = chReq;
      if (cmdWrEn) begin mMask = cmdMaskIn; mRot = cmdRotateIn; mDis = cmdDisableIn; end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      int expAck;
      expAck = (mGrant >= 0) ? (~(1 << mGrant)) & 4'hF : 4'hF;
      chk({phaseTag, " busReq"}, int'(busReq), int'((mSt == 1 && !mDis) || mSt == 2));
      chk({phaseTag, " chAckN"}, int'(chAckN), expAck);
      chk({phaseTag, " ownerDone"}, int'(ownerDone), int'(mDone));
    end
  end

  // ---------------- host processor model ----------------
  bit       hostOn = 1'b1;
  bit       manualHold = 1'b0;
  bit [1:0] hPipe = '0;
  always @(negedge clk) begin
    hPipe   <= {hPipe[0], busReq};
    holdAck <= hostOn ? hPipe[1] : manualHold;
  end

  // ---------------- watchdog ----------------
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cmdWrite(logic [NCH-1:0] m, bit r, bit d);
    @(negedge clk);
    cmdMaskIn = m; cmdRotateIn = r; cmdDisableIn = d; cmdWrEn = 1'b1;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic waitGrant(output int ch);
    ch = -1;
    for (int i = 0; i < 200 && chAckN == 4'hF; i++) @(negedge clk);
    for (int i = 0; i < NCH; i++) if (!chAckN[i]) ch = i;
  endtask

  task automatic dropBriefly(int ch);
    chReq[ch] = 1'b0;
    repeat (2) @(negedge clk);
    chReq[ch] = 1'b1;
  endtask

  initial begin
    int ch;
    int prev;
    repeat (4) @(negedge clk);
    chk("R1 busReq", int'(busReq), 0);
    chk("R1 chAckN", int'(chAckN), 15);
    chk("R1 ownerDone", int'(ownerDone), 0);
    rst = 1'b0;

    // R1/R9: masks are set after reset, so a request is ignored
    phaseTag = "R9";
    chReq = 4'b0001;
    repeat (6) @(negedge clk);
    chk("R9 masked after reset busReq", int'(busReq), 0);
    chReq = '0;

    // R2/R3: request then delayed hold-acknowledge
    cmdWrite(4'b0000, 1'b0, 1'b0);
    hostOn = 1'b0; manualHold = 1'b0;
    repeat (3) @(negedge clk);
    phaseTag = "R2";
    chReq = 4'b0100;
    @(negedge clk);
    chk("R2 busReq one edge", int'(busReq), 0);
    @(negedge clk);
    chk("R2 busReq two edges", int'(busReq), 1);
    phaseTag = "R3";
    repeat (5) @(negedge clk);
    chk("R3 no ack before hold", int'(chAckN), 15);
    manualHold = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 R4 ack ch2", int'(chAckN), 4'b1011);

    // R7: request drop ends service
    phaseTag = "R7";
    chReq = '0;
    @(negedge clk);
    chk("R7 still held", int'(chAckN), 4'b1011);
    @(negedge clk);
    chk("R7 ack released", int'(chAckN), 15);
    chk("R7 busReq low", int'(busReq), 0);
    chk("R7 done pulse", int'(ownerDone), 1);
    @(negedge clk);
    chk("R7 done one cycle", int'(ownerDone), 0);

    // R8: hold-acknowledge still high blocks a new request
    phaseTag = "R8";
    chReq = 4'b0010;
    repeat (6) @(negedge clk);
    chk("R8 blocked while hold high", int'(busReq), 0);
    @(negedge clk);
    manualHold = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busReq after hold low", int'(busReq), 1);
    // R3: withdraw before hold-acknowledge
    phaseTag = "R3";
    chReq = '0;
    repeat (3) @(negedge clk);
    chk("R3 withdrawn busReq", int'(busReq), 0);
    chk("R3 withdrawn no ack", int'(chAckN), 15);
    hostOn = 1'b1;
    repeat (4) @(negedge clk);

    // R5: fixed priority
    phaseTag = "R5";
    chReq = 4'b1111;
    for (int k = 0; k < 3; k++) begin
      waitGrant(ch);
      chk("R5 fixed winner", ch, 0);
      dropBriefly(ch);
    end
    chReq = 4'b1010;
    repeat (2) @(negedge clk);
    waitGrant(ch);
    chk("R5 fixed winner of 1,3", ch, 1);
    chReq = '0;
    repeat (12) @(negedge clk);

    // R6: rotating priority, pointer sits after channel 1
    phaseTag = "R6";
    cmdWrite(4'b0000, 1'b1, 1'b0);
    chReq = 4'b1111;
    prev = 1;
    for (int k = 0; k < 6; k++) begin
      waitGrant(ch);
      chk("R6 rotate order", ch, (prev + 1) % NCH);
      prev = ch;
      dropBriefly(ch);
    end

    // R7: terminal count ends service
    phaseTag = "R7";
    waitGrant(ch);
    tcIn = 1'b1;
    @(negedge clk);
    tcIn = 1'b0;
    chk("R7 tc releases", int'(chAckN), 15);
    chk("R7 tc done", int'(ownerDone), 1);

    // R10: global disable
    phaseTag = "R10";
    waitGrant(ch);
    chk("R10 granted before disable", int'(chAckN != 4'hF), 1);
    cmdWrite(4'b0000, 1'b1, 1'b1);
    @(negedge clk);
    chk("R10 grant ended", int'(chAckN), 15);
    repeat (10) @(negedge clk);
    chk("R10 busReq held low", int'(busReq), 0);

    // R9: masked channels skipped in fixed mode
    phaseTag = "R9";
    cmdWrite(4'b0011, 1'b0, 1'b0);
    waitGrant(ch);
    chk("R9 masked 0,1 winner", ch, 2);
    chReq = '0;
    repeat (12) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule